// File: doc/BRIEF.md
# Carrier Phase Tracking Loop

This block is the symbol-rate digital phase-locked loop of a quadrature receiver. Each accepted complex sample is turned back by the conjugate of a phasor from a numerically controlled oscillator (NCO), using a complex multiply built from three real products. The same transfer carries a signed phase-error word from a phase detector outside the block. A proportional-plus-integral filter turns that word into a frequency word that advances a 32-bit phase accumulator. The top ten accumulator bits address a 1024-entry sine/cosine table held in synchronous memory.

Samples enter and leave on valid/ready streams. The whole two-stage pipeline moves on a single enable, which is high when the output register is empty or is being read. Back-pressure therefore reaches the input in the same cycle: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While the output is stalled, the data and `out_valid` stay unchanged. No sample is dropped and the loop state does not move. The proportional and integral gains are plain registers with their own write enables, so a controller can widen or narrow the loop while it runs.

Top module: `ctl_carrier_loop`

## Requirements
- R1: A synchronous reset (`rst` high) clears the output valid, the phase accumulator, the integrator and the frequency word, and loads the gains with KP_RST=256 and KI_RST=16. After reset `in_ready` is 1.
- R2: `in_ready` = !`out_valid` || `out_ready`. A sample is accepted on an edge where `in_valid` and `in_ready` are both high. Its result is presented two edges later if the output is not stalled. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold.
- R3: Table entry k (0..1023) is A(k) = 2047*sin(2*pi*k/1024), rounded half away from zero. For an accumulator value p, the sine is A(p[31:22]) and the cosine is A((p[31:22]+256) mod 1024).
- R4: With cosine C and sine S, `out_i` = sat((I*C + Q*S + 1024) >>> 11) and `out_q` = sat((Q*C - I*S + 1024) >>> 11). Here >>> is an arithmetic right shift, and sat clamps to [-2048, 2047].
- R5: For a sample n with error e and gains Kp, Ki, the integrator becomes G(n) = G(n-1) + ((e*Ki) << 4) mod 2^32, and the frequency word becomes F(n) = ((e*Kp) << 4) + G(n) mod 2^32. The gains are unsigned, and e is a signed 12-bit value.
- R6: Sample n is de-rotated with phase p(n), where p(0)=0 and p(n+1) = p(n) + F(n-1) with F(-1)=0. The error sent with sample n therefore first turns sample n+2.
- R7: On an edge where no sample is accepted, the accumulator, the integrator and the frequency word do not change.
- R8: `kp_we`/`ki_we` load `kp_in`/`ki_in` on the edge where they are high. A sample accepted on that same edge uses the old gain, and every later sample uses the new one. A gain write does not clear the integrator.
- R9: After sample n is accepted, `nco_phase` shows p(n+1).
- R10: Full-scale inputs at a 45-degree phase clamp: I=Q=2047 gives `out_i`=2047 and `out_q`=0, and I=Q=-2048 gives `out_i`=-2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| in_err | input | 12 | Phase error carried with the sample, signed |
| out_valid | output | 1 | De-rotated sample valid |
| out_ready | input | 1 | Downstream takes the output |
| out_i | output | 12 | De-rotated in-phase, signed |
| out_q | output | 12 | De-rotated quadrature, signed |
| kp_we | input | 1 | Proportional gain write enable |
| kp_in | input | 16 | Proportional gain value, unsigned |
| ki_we | input | 1 | Integral gain write enable |
| ki_in | input | 16 | Integral gain value, unsigned |
| nco_phase | output | 32 | Phase accumulator |

## Verification
A de-rotated result is due two rising edges after its sample is accepted, or later by the number of stalled cycles. The new accumulator value shows on `nco_phase` one edge after acceptance. The bench drives inputs and reads outputs on falling edges. It keeps a cycle model of the two pipeline valid bits and compares `out_valid` with that model every cycle. Expected samples wait in a queue computed from the loop equations and are popped only on a real output handshake, so stalls and gaps cannot misalign the checks. `nco_phase` is compared with the modelled accumulator on every falling edge, which also shows that idle cycles leave the phase unchanged.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  // Rounded sine sample k of a table with `depth` entries and peak `amp`.
  function automatic int tbl_val(input int k, input int depth, input int amp);
    real r;
    r = real'(amp) * $sin(2.0 * 3.141592653589793 * real'(k) / real'(depth));
    if (r >= 0.0) return int'($floor(r + 0.5));
    else          return -int'($floor(-r + 0.5));
  endfunction

endpackage

// File: rtl/ctl_sincos_rom.sv
module ctl_sincos_rom #(
  parameter int AW = 10,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  output logic signed [SW-1:0] sin_q,
  output logic signed [SW-1:0] cos_q
);
  localparam int DEPTH = 1 << AW;
  localparam int AMP   = (1 << (SW-1)) - 1;
  localparam logic [AW-1:0] QTR = AW'(DEPTH / 4);

  logic signed [SW-1:0] tbl [DEPTH];
  logic [AW-1:0] caddr;

  initial begin
    for (int k = 0; k < DEPTH; k++) tbl[k] = SW'(ctl_pkg::tbl_val(k, DEPTH, AMP));
  end

  assign caddr = addr + QTR;

  // one-cycle read latency, held while the pipeline is frozen
  always_ff @(posedge clk) begin
    if (rd_en) begin
      sin_q <= tbl[addr];
      cos_q <= tbl[caddr];
    end
  end
endmodule

// File: rtl/ctl_loop_filter.sv
module ctl_loop_filter #(
  parameter int EW  = 12,
  parameter int GW  = 16,
  parameter int PW  = 32,
  parameter int GSH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic signed [EW-1:0] err,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  output logic [PW-1:0]        freq
);
  localparam int PRW = EW + GW + 1;

  logic signed [PRW-1:0] prod_p, prod_i;
  logic [PW-1:0] ext_p, ext_i, integ_q, integ_nx, freq_q;

  assign prod_p   = PRW'(err) * PRW'($signed({1'b0, kp}));
  assign prod_i   = PRW'(err) * PRW'($signed({1'b0, ki}));
  assign ext_p    = PW'(prod_p) << GSH;
  assign ext_i    = PW'(prod_i) << GSH;
  assign integ_nx = integ_q + ext_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      freq_q  <= '0;
    end else if (fire) begin
      integ_q <= integ_nx;
      freq_q  <= ext_p + integ_nx;
    end
  end

  assign freq = freq_q;

  p_idle_integ_r7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(integ_q) && $stable(freq_q)))
    else $error("integrator moved without a sample");
endmodule

// File: rtl/ctl_nco.sv
module ctl_nco #(
  parameter int PW = 32,
  parameter int AW = 10,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 rd_en,
  input  logic [PW-1:0]        freq,
  output logic [PW-1:0]        phase,
  output logic signed [SW-1:0] cos_o,
  output logic signed [SW-1:0] sin_o
);
  logic [PW-1:0] phase_q;

  // table addressed from the current register: the accumulator doubles
  // as the address stage, leaving two samples of loop delay in total
  ctl_sincos_rom #(.AW(AW), .SW(SW)) rom_i (
    .clk  (clk),
    .rd_en(rd_en),
    .addr (phase_q[PW-1 -: AW]),
    .sin_q(sin_o),
    .cos_q(cos_o)
  );

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (fire) phase_q <= phase_q + freq;
  end

  assign phase = phase_q;

  p_idle_phase_r7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(phase_q))
    else $error("phase moved without a sample");
endmodule

// File: rtl/ctl_derot_mix.sv
module ctl_derot_mix #(
  parameter int DW = 12,
  parameter int SW = 12
) (
  input  logic signed [DW-1:0] din_i,
  input  logic signed [DW-1:0] din_q,
  input  logic signed [SW-1:0] cos_v,
  input  logic signed [SW-1:0] sin_v,
  output logic signed [DW-1:0] dout_i,
  output logic signed [DW-1:0] dout_q
);
  localparam int MW = DW + SW + 3;
  localparam logic signed [MW-1:0] HI  = MW'((1 << (DW-1)) - 1);
  localparam logic signed [MW-1:0] LO  = -HI - MW'(1);
  localparam logic signed [MW-1:0] RND = MW'(1 << (SW-2));

  logic signed [MW-1:0] a_x, b_x, c_x, d_x;
  logic signed [MW-1:0] k1, k2, k3, re, im, re_r, im_r;

  // (a+jb)(c+jd) with d = -sin: three products, five adds
  always_comb begin
    a_x  = MW'(din_i);
    b_x  = MW'(din_q);
    c_x  = MW'(cos_v);
    d_x  = -MW'(sin_v);
    k1   = c_x * (a_x + b_x);
    k2   = a_x * (d_x - c_x);
    k3   = b_x * (c_x + d_x);
    re   = k1 - k3;
    im   = k1 + k2;
    re_r = (re + RND) >>> (SW-1);
    im_r = (im + RND) >>> (SW-1);
    if (re_r > HI)      dout_i = HI[DW-1:0];
    else if (re_r < LO) dout_i = LO[DW-1:0];
    else                dout_i = re_r[DW-1:0];
    if (im_r > HI)      dout_q = HI[DW-1:0];
    else if (im_r < LO) dout_q = LO[DW-1:0];
    else                dout_q = im_r[DW-1:0];
  end
endmodule

// File: rtl/ctl_carrier_loop.sv
module ctl_carrier_loop #(
  parameter int DW     = 12,
  parameter int EW     = 12,
  parameter int GW     = 16,
  parameter int PW     = 32,
  parameter int AW     = 10,
  parameter int SW     = 12,
  parameter int GSH    = 4,
  parameter int KP_RST = 256,
  parameter int KI_RST = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [EW-1:0] in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  input  logic          kp_we,
  input  logic [GW-1:0] kp_in,
  input  logic          ki_we,
  input  logic [GW-1:0] ki_in,
  output logic [PW-1:0] nco_phase
);
  logic en, fire;
  logic s1_valid, ov_q;
  logic signed [DW-1:0] s1_i, s1_q, mix_i, mix_q, oi_q, oq_q;
  logic signed [SW-1:0] cos_v, sin_v;
  logic [GW-1:0] kp_q, ki_q;
  logic [PW-1:0] freq;

  assign en       = !ov_q || out_ready;
  assign in_ready = en;
  assign fire     = in_valid && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_q <= GW'(KP_RST);
      ki_q <= GW'(KI_RST);
    end else begin
      if (kp_we) kp_q <= kp_in;
      if (ki_we) ki_q <= ki_in;
    end
  end

  ctl_loop_filter #(.EW(EW), .GW(GW), .PW(PW), .GSH(GSH)) filt_i (
    .clk (clk),
    .rst (rst),
    .fire(fire),
    .err ($signed(in_err)),
    .kp  (kp_q),
    .ki  (ki_q),
    .freq(freq)
  );

  ctl_nco #(.PW(PW), .AW(AW), .SW(SW)) nco_i (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .rd_en(en),
    .freq (freq),
    .phase(nco_phase),
    .cos_o(cos_v),
    .sin_o(sin_v)
  );

  // stage 1: sample waits beside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (en) begin
      s1_valid <= in_valid;
    end
    if (en) begin
      s1_i <= $signed(in_i);
      s1_q <= $signed(in_q);
    end
  end

  ctl_derot_mix #(.DW(DW), .SW(SW)) mix_i_u (
    .din_i (s1_i),
    .din_q (s1_q),
    .cos_v (cos_v),
    .sin_v (sin_v),
    .dout_i(mix_i),
    .dout_q(mix_q)
  );

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
    end else if (en) begin
      ov_q <= s1_valid;
    end
    if (en) begin
      oi_q <= mix_i;
      oq_q <= mix_q;
    end
  end

  assign out_valid = ov_q;
  assign out_i     = oi_q;
  assign out_q     = oq_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && nco_phase == '0))
    else $error("reset did not clear loop state");

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)))
    else $error("output changed while stalled");

  p_out_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(s1_valid))
    else $error("output valid without a staged sample");

  p_gain_load_r8: assert property (@(posedge clk) disable iff (rst)
    kp_we |=> (kp_q == $past(kp_in)))
    else $error("proportional gain not loaded");
endmodule

// File: tb/ctl_carrier_loop_tb.sv
module ctl_carrier_loop_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1, kp_we = 1'b0, ki_we = 1'b0;
  logic [11:0] in_i = '0, in_q = '0, in_err = '0;
  logic [15:0] kp_in = '0, ki_in = '0;
  logic in_ready, out_valid;
  logic [11:0] out_i, out_q;
  logic [31:0] nco_phase;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  // model state
  logic [31:0] m_phase = '0, m_freq = '0, m_integ = '0;
  int m_kp = 256, m_ki = 16;
  bit m_s1 = 0, m_ov = 0;
  int q_i[$];
  int q_q[$];

  always #4 clk = ~clk;

  ctl_carrier_loop dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .kp_we(kp_we), .kp_in(kp_in), .ki_we(ki_we), .ki_in(ki_in),
    .nco_phase(nco_phase)
  );

  function automatic int tb_amp(input int k);
    real r;
    r = 2047.0 * $sin(2.0 * $acos(-1.0) * real'(k) / 1024.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int tb_sat(input longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // model of one accepted sample: outputs from the current phase, then loop update
  task automatic model_fire(input int di, input int dq, input int de);
    int a, c, s;
    longint re, im;
    a  = int'(m_phase[31:22]);
    s  = tb_amp(a);
    c  = tb_amp((a + 256) % 1024);
    re = longint'(di) * c + longint'(dq) * s;
    im = longint'(dq) * c - longint'(di) * s;
    q_i.push_back(tb_sat((re + 1024) >>> 11));
    q_q.push_back(tb_sat((im + 1024) >>> 11));
    m_phase = m_phase + m_freq;
    m_integ = m_integ + 32'((longint'(de) * m_ki) << 4);
    m_freq  = 32'((longint'(de) * m_kp) << 4) + m_integ;
  endtask

  task automatic step(input bit v, input int di, input int dq, input int de, input bit ordy,
                      input bit kw, input int kpv, input bit iw, input int kiv);
    bit en;
    int ei, eq;
    @(negedge clk);
    chk(nco_phase == m_phase, cur_tag, "nco_phase", nco_phase, m_phase);
    chk(out_valid == m_ov, "R2", "out_valid", out_valid, m_ov);
    out_ready = ordy;
    if (out_valid && ordy) begin
      if (q_i.size() == 0) begin
        chk(1'b0, "R2", "unexpected output", 1, 0);
      end else begin
        ei = q_i.pop_front();
        eq = q_q.pop_front();
        chk($signed(out_i) == ei, cur_tag, "out_i", $signed(out_i), ei);
        chk($signed(out_q) == eq, cur_tag, "out_q", $signed(out_q), eq);
      end
    end
    in_valid = v;
    in_i = 12'(di);
    in_q = 12'(dq);
    in_err = 12'(de);
    kp_we = kw;
    kp_in = 16'(kpv);
    ki_we = iw;
    ki_in = 16'(kiv);
    #1;
    en = !m_ov || ordy;
    chk(in_ready == en, "R2", "in_ready", in_ready, en);
    if (v && en) model_fire(di, dq, de);
    if (kw) m_kp = kpv;
    if (iw) m_ki = kiv;
    if (en) begin
      m_ov = m_s1;
      m_s1 = v;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(nco_phase == 32'd0, "R1", "nco_phase after reset", nco_phase, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // default gains drive the loop (R1, R5, R9)
    cur_tag = "R1/R5/R9";
    step(1, 1000, -500, 100, 1, 0, 0, 0, 0);
    step(1, -300, 700, -40, 1, 0, 0, 0, 0);
    step(1, 123, 456, 7, 1, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);

    // steer to 45 degrees, then full-scale inputs clamp (R10, R3, R4, R6)
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_phase = '0; m_freq = '0; m_integ = '0; m_kp = 256; m_ki = 16;
    m_s1 = 0; m_ov = 0;
    q_i.delete(); q_q.delete();
    cur_tag = "R10/R3/R4/R6";
    step(0, 0, 0, 0, 1, 1, 32768, 1, 0);
    step(1, 5, 5, 1024, 1, 0, 0, 0, 0);
    step(1, 5, 5, 0, 1, 0, 0, 0, 0);
    step(1, 2047, 2047, 0, 1, 0, 0, 0, 0);
    step(1, -2048, -2048, 0, 1, 0, 0, 0, 0);
    step(1, 2047, -2048, 0, 1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk(m_phase == 32'h2000_0000, "R10", "model phase at 45 deg", m_phase, 32'h2000_0000);

    // gain written on the same edge as an accepted sample (R8)
    cur_tag = "R8";
    step(1, 800, 300, 200, 1, 1, 4000, 1, 300);
    step(1, -800, 100, -150, 1, 0, 0, 0, 0);
    step(1, 50, -900, 60, 1, 1, 10, 0, 0);
    step(1, 400, 400, 90, 1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);

    // stall and idle: nothing moves while held (R7, R2)
    cur_tag = "R7/R2";
    step(1, 600, -600, 30, 0, 0, 0, 0, 0);
    step(1, 700, -700, 31, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(1, 900, 900, 500, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);

    // constrained random stream (R3, R4, R5, R6)
    cur_tag = "R3/R4/R5/R6";
    for (int k = 0; k < 4000; k++) begin
      bit v, ordy, kw, iw;
      int di, dq, de;
      v    = ($urandom % 10) < 7;
      ordy = (k > 3000) ? 1'b1 : (($urandom % 4) != 0);
      di   = int'($urandom % 4096) - 2048;
      dq   = int'($urandom % 4096) - 2048;
      de   = (($urandom % 8) == 0) ? int'($urandom % 4096) - 2048
                                   : int'($urandom % 256) - 128;
      kw   = ($urandom % 50) == 0;
      iw   = ($urandom % 60) == 0;
      step(v, di, dq, de, ordy, kw, int'($urandom % 2048), iw, int'($urandom % 64));
    end
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk(q_i.size() == 0, "R2", "outputs left undelivered", q_i.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule